// File: doc/BRIEF.md
# Bank Open-Row State Tracker

This block follows the open or closed state of every bank of a DDR3-style memory by watching a decoded command stream. Each command has an opcode, a bank field and a row field. An ACTIVE opens one row in one bank. That row stays open until a PRECHARGE to the same bank, or a PRECHARGE-ALL, closes it. READ and WRITE do not change the state. They are only checked against it.

The block raises two registered flags. The first marks an ACTIVE issued to a bank that already holds an open row, whether the row is the same or a different one. Such an ACTIVE leaves the tracked state unchanged. The second marks a READ or WRITE sent to a bank with no open row.

A combinational lookup port takes a bank and a row. It answers whether an access there would be a page hit, a page miss or a closed-bank access. A controller uses this answer to decide whether a precharge must come before it opens another row.

Top module: `bank_row_tracker`

## Requirements
- R1: While reset is held and after it is released, every bank is closed, `open_mask` is zero and both violation flags are low.
- R2: A valid ACTIVE (`cmd_op`=1) to a closed bank opens that bank on `cmd_row`. The bank's bit in `open_mask` is set from the cycle after the command.
- R3: `qry_result` is combinational from the current state. It is 1 (hit) when `qry_bank` is open on `qry_row`, 2 (miss) when it is open on another row, and 0 (closed) when the bank has no open row. The value 3 never appears.
- R4: A valid ACTIVE to a bank that already has an open row, on any row, drives `viol_act` high in the following cycle. It leaves the open mask and the stored row unchanged.
- R5: A valid PRECHARGE (`cmd_op`=2) closes only the addressed bank from the next cycle. A PRECHARGE to a closed bank has no effect and raises no flag.
- R6: A valid PRECHARGE-ALL (`cmd_op`=3) closes every bank by the next cycle.
- R7: A valid READ (`cmd_op`=4) or WRITE (`cmd_op`=5) to a closed bank drives `viol_acc` high in the following cycle. To an open bank it raises no flag and changes no state.
- R8: When `cmd_valid` is low, or the opcode is 0 (no operation), state does not change and no flag is raised.
- R9: Each violation flag is high for exactly the one cycle after each offending command and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command qualifier |
| cmd_op | input | 3 | Opcode: 0 none, 1 ACTIVE, 2 PRECHARGE, 3 PRECHARGE-ALL, 4 READ, 5 WRITE |
| cmd_bank | input | 3 | Bank addressed by the command |
| cmd_row | input | 16 | Row carried by ACTIVE |
| qry_bank | input | 3 | Lookup bank |
| qry_row | input | 16 | Lookup row |
| qry_result | output | 2 | 0 closed, 1 hit, 2 miss |
| open_mask | output | 8 | One bit per bank, set while the bank is open |
| viol_act | output | 1 | ACTIVE to an already-open bank, one cycle after the command |
| viol_acc | output | 1 | READ/WRITE to a closed bank, one cycle after the command |

## Verification
A command sampled at clock edge N changes `open_mask`, the stored rows and both flags at edge N. All of these are therefore due one cycle after the command was driven. The driver pushes the expected mask and flags for each command into a queue as soon as that edge has passed. The monitor pops and compares the entry at the next falling edge, so each result is checked exactly one cycle after its command.

Lookups have zero latency. They are checked mid-cycle, after the query inputs settle, against a bank model kept in the bench.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ACT   = 3'd1,
    OP_PRE   = 3'd2,
    OP_PREA  = 3'd3,
    OP_RD    = 3'd4,
    OP_WR    = 3'd5
  } brt_op_e;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HIT    = 2'd1,
    LK_MISS   = 2'd2
  } brt_lookup_e;
endpackage

// File: rtl/brt_rst_sync.sv
module brt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/brt_bank_slot.sv
module brt_bank_slot #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);
  logic             open_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    if (close_en) begin
      open_d = 1'b0;
    end else if (open_en) begin
      open_d = 1'b1;
      row_d  = row_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      row_q  <= row_d;
    end
  end
endmodule

// File: rtl/brt_cmd_check.sv
module brt_cmd_check
  import brt_pkg::*;
#(
  parameter int BANK_W = 3,
  localparam int NB = 1 << BANK_W
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [NB-1:0]     open_vec,
  output logic [NB-1:0]     open_en,
  output logic [NB-1:0]     close_en,
  output logic              act_bad,
  output logic              acc_bad
);
  logic [NB-1:0] sel;
  logic          tgt_open;

  always_comb begin
    sel      = '0;
    sel[cmd_bank] = 1'b1;
    tgt_open = open_vec[cmd_bank];
    open_en  = '0;
    close_en = '0;
    act_bad  = 1'b0;
    acc_bad  = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        OP_ACT: begin
          if (tgt_open) act_bad = 1'b1;
          else          open_en = sel;
        end
        OP_PRE:  close_en = sel;
        OP_PREA: close_en = '1;
        OP_RD, OP_WR: acc_bad = !tgt_open;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brt_lookup.sv
module brt_lookup
  import brt_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  localparam int NB = 1 << BANK_W
) (
  input  logic [NB-1:0]            open_vec,
  input  logic [NB-1:0][ROW_W-1:0] row_vec,
  input  logic [BANK_W-1:0]        qry_bank,
  input  logic [ROW_W-1:0]         qry_row,
  output logic [1:0]               qry_result
);
  always_comb begin
    if (!open_vec[qry_bank])              qry_result = LK_CLOSED;
    else if (row_vec[qry_bank] == qry_row) qry_result = LK_HIT;
    else                                  qry_result = LK_MISS;
  end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  localparam int NB = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [BANK_W-1:0] qry_bank,
  input  logic [ROW_W-1:0]  qry_row,
  output logic [1:0]        qry_result,
  output logic [NB-1:0]     open_mask,
  output logic              viol_act,
  output logic              viol_acc
);
  logic                     rst_n_i;
  logic [NB-1:0]            open_vec;
  logic [NB-1:0][ROW_W-1:0] row_vec;
  logic [NB-1:0]            open_en;
  logic [NB-1:0]            close_en;
  logic                     act_bad;
  logic                     acc_bad;
  logic                     viol_act_d;
  logic                     viol_acc_d;

  brt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  brt_cmd_check #(.BANK_W(BANK_W)) u_chk_cmd (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .open_vec(open_vec), .open_en(open_en), .close_en(close_en),
    .act_bad(act_bad), .acc_bad(acc_bad)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    brt_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk(clk), .rst_n(rst_n_i),
      .open_en(open_en[b]), .close_en(close_en[b]),
      .row_in(cmd_row), .open_q(open_vec[b]), .row_q(row_vec[b])
    );
  end

  brt_lookup #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_lookup (
    .open_vec(open_vec), .row_vec(row_vec),
    .qry_bank(qry_bank), .qry_row(qry_row), .qry_result(qry_result)
  );

  always_comb begin
    viol_act_d = act_bad;
    viol_acc_d = acc_bad;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      viol_act <= 1'b0;
      viol_acc <= 1'b0;
    end else begin
      viol_act <= viol_act_d;
      viol_acc <= viol_acc_d;
    end
  end

  assign open_mask = open_vec;
endmodule

// File: rtl/brt_chk.sv
module brt_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  localparam int NB = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [BANK_W-1:0] qry_bank,
  input logic [1:0]        qry_result,
  input logic [NB-1:0]     open_mask,
  input logic              viol_act,
  input logic              viol_acc
);
  logic act_c, pre_c, prea_c, acc_c, idle_c;
  assign act_c  = cmd_valid && cmd_op == 3'd1;
  assign pre_c  = cmd_valid && cmd_op == 3'd2;
  assign prea_c = cmd_valid && cmd_op == 3'd3;
  assign acc_c  = cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5);
  assign idle_c = !cmd_valid || cmd_op == 3'd0;

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    act_c && !open_mask[cmd_bank] |=> open_mask[$past(cmd_bank)] && !viol_act);
  // R4
  act_open_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    act_c && open_mask[cmd_bank] |=> viol_act && $stable(open_mask));
  // R5
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    pre_c |=> !open_mask[$past(cmd_bank)] && !viol_act && !viol_acc);
  // R6
  prea_all_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    prea_c |=> open_mask == '0);
  // R7
  acc_closed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    acc_c |=> viol_acc == !$past(open_mask[cmd_bank]) && $stable(open_mask));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    idle_c |=> $stable(open_mask) && !viol_act && !viol_acc);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(viol_act && viol_acc));
  // R3
  lookup_code_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    qry_result != 2'd3 && ((qry_result == 2'd0) == !open_mask[qry_bank]));
endmodule

bind bank_row_tracker brt_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_brt_chk (
  .clk(clk), .rst_n_i(rst_n_i), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .qry_bank(qry_bank), .qry_result(qry_result),
  .open_mask(open_mask), .viol_act(viol_act), .viol_acc(viol_acc)
);

// File: tb/sim_bank_row_tracker.sv
`timescale 1ns/1ps
module sim_bank_row_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [15:0] cmd_row;
  logic [2:0]  qry_bank;
  logic [15:0] qry_row;
  logic [1:0]  qry_result;
  logic [7:0]  open_mask;
  logic        viol_act;
  logic        viol_acc;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [7:0] mask;
    logic       va;
    logic       vc;
  } exp_t;
  exp_t exp_q[$];

  logic        m_open [8];
  logic [15:0] m_row  [8];

  always #4 clk = ~clk;

  bank_row_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .qry_bank(qry_bank),
    .qry_row(qry_row), .qry_result(qry_result), .open_mask(open_mask),
    .viol_act(viol_act), .viol_acc(viol_acc)
  );

  function automatic logic [7:0] model_mask();
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = m_open[i];
    return m;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply one command, update model, push expected outputs
  task automatic issue(input bit v, input logic [2:0] op, input logic [2:0] b,
                       input logic [15:0] r);
    exp_t e;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_bank = b; cmd_row = r;
    @(posedge clk);
    #1;
    e.va = 1'b0; e.vc = 1'b0;
    if (v) begin
      case (op)
        3'd1: if (m_open[b]) e.va = 1'b1; else begin m_open[b] = 1'b1; m_row[b] = r; end
        3'd2: m_open[b] = 1'b0;
        3'd3: for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
        3'd4, 3'd5: e.vc = !m_open[b];
        default: ;
      endcase
    end
    e.mask = model_mask();
    exp_q.push_back(e);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  // monitor: compare one cycle after each command
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R2/R5/R6 mask", open_mask, e.mask);
      check("R4/R9 viol_act", viol_act, e.va);
      check("R7/R9 viol_acc", viol_acc, e.vc);
    end
  end

  task automatic lookup(input string req, input logic [2:0] b, input logic [15:0] r);
    int exp;
    @(negedge clk);
    #1;
    qry_bank = b; qry_row = r;
    #1;
    exp = !m_open[b] ? 0 : (m_row[b] == r ? 1 : 2);
    check(req, qry_result, exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = '0; cmd_row = '0;
    qry_bank = '0; qry_row = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1 mask in reset", open_mask, 0);
    check("R1 flags in reset", {viol_act, viol_acc}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 mask after reset", open_mask, 0);
    lookup("R1/R3 closed after reset", 3'd5, 16'h0);

    issue(1, 3'd1, 3'd2, 16'h1234);          // R2 open bank 2
    lookup("R3 hit", 3'd2, 16'h1234);
    lookup("R3 miss", 3'd2, 16'h1235);
    lookup("R3 closed other bank", 3'd3, 16'h1234);
    issue(1, 3'd1, 3'd7, 16'hFFFF);          // R2 open bank 7, max row
    issue(1, 3'd1, 3'd2, 16'h0042);          // R4 different row
    lookup("R4 row kept", 3'd2, 16'h1234);
    issue(1, 3'd1, 3'd2, 16'h1234);          // R4 same row
    issue(1, 3'd4, 3'd2, 16'h0);             // R7 read open bank
    issue(1, 3'd5, 3'd0, 16'h0);             // R7 write closed bank
    issue(1, 3'd4, 3'd1, 16'h0);             // R7 read closed bank
    issue(0, 3'd1, 3'd0, 16'h7777);          // R8 invalid ACT
    issue(1, 3'd0, 3'd0, 16'h7777);          // R8 no-op
    lookup("R8 no open from idle", 3'd0, 16'h7777);
    issue(1, 3'd2, 3'd4, 16'h0);             // R5 precharge closed bank
    issue(1, 3'd2, 3'd2, 16'h0);             // R5 precharge bank 2
    lookup("R5 bank2 closed", 3'd2, 16'h1234);
    lookup("R5 bank7 still hit", 3'd7, 16'hFFFF);
    issue(1, 3'd1, 3'd2, 16'h0042);          // R2 reopen after precharge
    issue(1, 3'd1, 3'd0, 16'h0001);
    issue(1, 3'd3, 3'd5, 16'h0);             // R6 precharge all
    lookup("R6 bank7 closed", 3'd7, 16'hFFFF);
    issue(1, 3'd5, 3'd7, 16'h0);             // R7 write after PREA
    for (int b = 0; b < 8; b++) issue(1, 3'd1, b[2:0], 16'(b * 3 + 1));
    for (int b = 0; b < 8; b++) lookup("R3 all banks hit", b[2:0], 16'(b * 3 + 1));
    issue(1, 3'd1, 3'd6, 16'h0);             // R4 back-to-back flags
    issue(1, 3'd1, 3'd6, 16'h0);
    issue(1, 3'd3, 3'd0, 16'h0);             // R6
    @(negedge clk); @(negedge clk);
    check("R9 flags idle", {viol_act, viol_acc}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule